// File: doc/BRIEF.md
# Two-wire register target for a clock generator

This block lets a host on a two-wire serial bus read and write a bank of four 8-bit control registers. It runs on the system clock and oversamples the bus lines. It finds start, repeated start and stop conditions and answers only to its own address. It drives the data line through an open-drain enable, where a high `sda_oe_o` pulls the line low. The register contents are always available as a parallel bus, so the enables and the spread-spectrum controls of the clock generator can be wired straight to them.

The byte after the address is a command. When its top bit is set, the transfer is an indexed single-register access. When the command is all zero, the transfer is a sequential block access. A block write carries a length byte before its data. A block read returns a length byte before the register data.

Top module: `smb_reg_target`

## Requirements
- R1: After reset `regs_o` is 32'h00EA_007C and `sda_oe_o` is low. Register k sits in `regs_o[8k+7:8k]`.
- R2: The target acknowledges only the address byte whose upper seven bits are 7'h69. Bit 0 is 0 for a write and 1 for a read. Any other address gets no acknowledge, and every later byte is ignored until the next start or stop.
- R3: A command byte with bit 7 set selects single-register mode with index bits 6:0. The target acknowledges it only when the index is below 4. Otherwise it sends no acknowledge and ignores the rest of the transfer.
- R4: A command byte with bit 7 clear selects block mode. The target acknowledges it only when bits 6:0 are all zero. Otherwise it sends no acknowledge and ignores the rest of the transfer.
- R5: In single-register mode, the data byte after the command is written to the indexed register and acknowledged. It shows on `regs_o` once its eighth bit has been clocked.
- R6: After a single-register command, a repeated start and the read address, the target sends the indexed register MSB first. Each byte the host acknowledges is followed by the next higher register. Reads past register 3 return 8'h00.
- R7: In block-write mode the first byte after the command is a length byte. The target acknowledges it and does not use it. The data bytes that follow fill registers 0, 1, 2 and 3 in rising order. Any bytes beyond register 3 are acknowledged and discarded.
- R8: In block-read mode the target first sends 8'h04, then registers 0 to 3 in rising order, then 8'h00 for any further acknowledged bytes.
- R9: A stop after any complete byte of a block write ends the transfer. The bytes already written keep their values and the other registers keep theirs.
- R10: A start or stop that arrives once two to seven clock pulses of a byte have passed cancels the transfer. Nothing is written, SDA is released, and the following bytes are ignored until a fresh start.
- R11: The target changes `sda_oe_o` only while SCL is low. It samples SDA on SCL rising edges, and it releases SDA on the SCL falling edge that ends each acknowledge bit it drives.
- R12: After the host answers a read byte with a not-acknowledge, the target keeps SDA released until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the data line |
| regs_o | output | 32 | Register bank contents, register k in bits 8k+7:8k |

## Verification
Two events can land in the same system-clock cycle. When the eighth SCL rise of a data byte is detected, the register write is committed and the acknowledge decision for that byte is taken in that same cycle, including for a byte that lands past the end of the bank. The bench provokes this with random block writes of zero to six data bytes and with a directed six-byte write. For each one it checks that every byte drew an acknowledge, that `regs_o` holds exactly the first four data bytes, and that a read-back agrees with a bench model of the bank.

// File: rtl/smb_reg_pkg.sv
package smb_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_SKIP
  } st_e;

  typedef enum logic [1:0] {K_ADDR, K_CMD, K_WCNT, K_WDAT} kind_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, sda_s, scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edge while SCL held high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int                NREG    = 4,
  parameter int                PW      = 3,
  parameter logic [NREG*8-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PW-1:0]     idx_i,
  input  logic [7:0]        wdata_i,
  output logic [NREG*8-1:0] regs_o
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [7:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        r_q <= RST_VAL[8*k +: 8];
      else if (we_i && idx_i == PW'(k))   r_q <= wdata_i;
    end
    assign regs_o[8*k +: 8] = r_q;
  end
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int          NREG    = 4,
  parameter int          PW      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [NREG*8-1:0] regs_i,
  output logic              wr_en_o,
  output logic [PW-1:0]     wr_idx_o,
  output logic [7:0]        wr_data_o,
  output logic              sda_oe_o,
  output st_e               st_o,
  output logic [PW-1:0]     ptr_o
);
  st_e         st_q;
  kind_e       kind_q;
  logic [2:0]  cnt_q;
  logic [1:0]  ph_q;
  logic [7:0]  sh_q;
  logic        oe_q, rd_q, blk_q, pend_q;
  logic [PW-1:0] ptr_q, idx_q;
  logic [7:0]  byte_in, tx_byte;
  logic        last_bit, in_range, cmd_byte_ok, cmd_blk_ok;

  assign byte_in     = {sh_q[6:0], sda_i};
  assign last_bit    = scl_rise_i && cnt_q == 3'd7;
  assign in_range    = int'(ptr_q) < NREG;
  assign cmd_byte_ok = byte_in[7] && int'(byte_in[6:0]) < NREG;
  assign cmd_blk_ok  = !byte_in[7] && byte_in[6:0] == 7'd0;

  always_comb begin
    if (pend_q)        tx_byte = 8'(NREG);
    else if (in_range) tx_byte = regs_i[8*int'(ptr_q) +: 8];
    else               tx_byte = 8'h00;
  end

  assign wr_en_o   = st_q == ST_RX && kind_q == K_WDAT && last_bit && in_range
                     && !start_i && !stop_i;
  assign wr_idx_o  = ptr_q;
  assign wr_data_o = byte_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      kind_q <= K_ADDR;
      cnt_q  <= '0;
      ph_q   <= '0;
      sh_q   <= '0;
      oe_q   <= 1'b0;
      rd_q   <= 1'b0;
      blk_q  <= 1'b1;
      pend_q <= 1'b0;
      ptr_q  <= '0;
      idx_q  <= '0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else if (start_i) begin
      oe_q <= 1'b0;
      // one rise is allowed: a repeated start raises SCL before SDA falls
      if ((st_q == ST_RX || st_q == ST_TX) && cnt_q > 3'd1) begin
        st_q <= ST_IDLE;
      end else begin
        st_q   <= ST_RX;
        kind_q <= K_ADDR;
        cnt_q  <= '0;
      end
    end else begin
      unique case (st_q)
        ST_RX: if (scl_rise_i) begin
          sh_q <= byte_in;
          if (cnt_q != 3'd7) begin
            cnt_q <= cnt_q + 3'd1;
          end else begin
            cnt_q <= '0;
            ph_q  <= '0;
            rd_q  <= 1'b0;
            st_q  <= ST_RX_ACK;
            unique case (kind_q)
              K_ADDR: begin
                if (byte_in[7:1] != DEV_ADDR) begin
                  st_q <= ST_SKIP;
                end else if (byte_in[0]) begin
                  rd_q   <= 1'b1;
                  pend_q <= blk_q;
                  ptr_q  <= blk_q ? '0 : idx_q;
                end else begin
                  kind_q <= K_CMD;
                end
              end
              K_CMD: begin
                if (cmd_byte_ok) begin
                  blk_q  <= 1'b0;
                  idx_q  <= byte_in[PW-1:0];
                  ptr_q  <= byte_in[PW-1:0];
                  kind_q <= K_WDAT;
                end else if (cmd_blk_ok) begin
                  blk_q  <= 1'b1;
                  kind_q <= K_WCNT;
                end else begin
                  st_q <= ST_SKIP;
                end
              end
              K_WCNT: begin
                ptr_q  <= '0;
                kind_q <= K_WDAT;
              end
              K_WDAT: if (in_range) ptr_q <= ptr_q + 1'b1;
              default: st_q <= ST_SKIP;
            endcase
          end
        end

        ST_RX_ACK: begin
          if (ph_q == 2'd0 && scl_fall_i) begin
            oe_q <= 1'b1;
            ph_q <= 2'd1;
          end else if (ph_q == 2'd1 && scl_rise_i) begin
            ph_q <= 2'd2;
          end else if (ph_q == 2'd2 && scl_fall_i) begin
            cnt_q <= '0;
            if (rd_q) begin
              sh_q <= tx_byte;
              oe_q <= ~tx_byte[7];
              st_q <= ST_TX;
              if (pend_q)        pend_q <= 1'b0;
              else if (in_range) ptr_q  <= ptr_q + 1'b1;
            end else begin
              oe_q <= 1'b0;
              st_q <= ST_RX;
            end
          end
        end

        ST_TX: begin
          if (scl_rise_i) begin
            if (cnt_q == 3'd7) begin
              cnt_q <= '0;
              ph_q  <= '0;
              st_q  <= ST_TX_ACK;
            end else begin
              cnt_q <= cnt_q + 3'd1;
            end
          end else if (scl_fall_i && cnt_q != 3'd0) begin
            oe_q <= ~sh_q[6];
            sh_q <= {sh_q[6:0], 1'b0};
          end
        end

        ST_TX_ACK: begin
          if (ph_q == 2'd0 && scl_fall_i) begin
            oe_q <= 1'b0;
            ph_q <= 2'd1;
          end else if (ph_q == 2'd1 && scl_rise_i) begin
            if (sda_i) st_q <= ST_SKIP;
            else       ph_q <= 2'd2;
          end else if (ph_q == 2'd2 && scl_fall_i) begin
            cnt_q <= '0;
            sh_q  <= tx_byte;
            oe_q  <= ~tx_byte[7];
            st_q  <= ST_TX;
            if (pend_q)        pend_q <= 1'b0;
            else if (in_range) ptr_q  <= ptr_q + 1'b1;
          end
        end

        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
  assign st_o     = st_q;
  assign ptr_o    = ptr_q;
endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target
  import smb_reg_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h69,
  parameter int                NREG        = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NREG*8-1:0] RST_VAL     = 32'h00EA_007C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int PW = $clog2(NREG + 1);

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en;
  logic [PW-1:0] wr_idx, ptr;
  logic [7:0]    wr_data;
  st_e           st;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  smb_proto_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .PW(PW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .regs_i     (regs_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o),
    .st_o       (st),
    .ptr_o      (ptr)
  );

  smb_reg_bank #(.NREG(NREG), .PW(PW), .RST_VAL(RST_VAL)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .idx_i   (wr_idx),
    .wdata_i (wr_data),
    .regs_o  (regs_o)
  );
endmodule

// File: rtl/smb_reg_target_chk.sv
module smb_reg_target_chk
  import smb_reg_pkg::*;
#(
  parameter int NREG = 4,
  parameter int PW   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe_i,
  input logic [NREG*8-1:0] regs_i,
  input logic              wr_en_i,
  input logic              scl_fall_i,
  input logic              stop_i,
  input st_e               st_i,
  input logic [PW-1:0]     ptr_i
);
  // R11: pull-down enable moves only right after an SCL fall
  a_r11_oe_moves_on_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> $past(scl_fall_i));

  // R5: bank contents change only through a committed write
  a_r5_regs_change_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_i != $past(regs_i)) |-> $past(wr_en_i));

  // R10: stop drops the transfer and frees the line
  a_r10_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_i == ST_IDLE && !sda_oe_i));

  // R12: no drive while idle or ignoring the bus
  a_r12_quiet_when_ignoring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE || st_i == ST_SKIP) |-> !sda_oe_i);

  // R7: register pointer saturates one past the last register
  a_r7_ptr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_i) <= NREG);
endmodule

bind smb_reg_target smb_reg_target_chk #(.NREG(NREG), .PW(PW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_i   (sda_oe_o),
  .regs_i     (regs_o),
  .wr_en_i    (wr_en),
  .scl_fall_i (scl_fall),
  .stop_i     (stop_det),
  .st_i       (st),
  .ptr_i      (ptr)
);

// File: tb/tb_smb_reg_target.sv
module tb_smb_reg_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_scl = 1'b1;
  logic h_sda = 1'b1;
  logic sda_oe;
  logic [31:0] regs;
  wire sda_bus = h_sda & ~sda_oe;

  int checks = 0;
  int fails = 0;
  int r11_viol = 0;
  bit done = 1'b0;
  logic [7:0] mdl [4];

  always #5 clk = ~clk;

  smb_reg_target dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(h_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_pack();
    return {mdl[3], mdl[2], mdl[1], mdl[0]};
  endfunction

  function automatic logic [7:0] model_rd(input int k);
    return (k < 4) ? mdl[k] : 8'h00;
  endfunction

  // R11 monitor: enable must not move while host SCL is high
  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (rst_n && sda_oe !== oe_prev && h_scl) r11_viol++;
    oe_prev <= sda_oe;
  end

  task automatic qw(); repeat (5) @(negedge clk); endtask
  task automatic bus_start(); h_sda = 1; h_scl = 1; qw(); h_sda = 0; qw(); h_scl = 0; qw(); endtask
  task automatic bus_rstart(); h_sda = 1; qw(); h_scl = 1; qw(); h_sda = 0; qw(); h_scl = 0; qw(); endtask
  task automatic bus_stop(); h_sda = 0; qw(); h_scl = 1; qw(); h_sda = 1; qw(); endtask
  task automatic send_bit(input bit b); h_sda = b; qw(); h_scl = 1; qw(); qw(); h_scl = 0; qw(); endtask
  task automatic get_bit(output bit b); h_sda = 1; qw(); h_scl = 1; qw(); b = sda_bus; qw(); h_scl = 0; qw(); endtask

  task automatic wr_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input bit host_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    send_bit(!host_ack);
  endtask

  task automatic byte_write(input int idx, input logic [7:0] d);
    bit a0, a1, a2;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h80 | 8'(idx), a1); wr_byte(d, a2); bus_stop();
    mdl[idx] = d;
    chk(a0 && a1 && a2, "R5 acks", {29'd0, a0, a1, a2}, 32'd7);
    chk(regs == model_pack(), "R5 regs", regs, model_pack());
  endtask

  task automatic block_write(input int n, input bit stop_only_check);
    bit a, all_ack;
    logic [7:0] d;
    all_ack = 1;
    bus_start(); wr_byte(8'hD2, a); all_ack &= a; wr_byte(8'h00, a); all_ack &= a;
    wr_byte(8'(n), a); all_ack &= a;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      wr_byte(d, a); all_ack &= a;
      if (k < 4) mdl[k] = d;
    end
    bus_stop();
    chk(all_ack, "R7 acks", {31'd0, all_ack}, 32'd1);
    chk(regs == model_pack(), stop_only_check ? "R9 regs" : "R7 regs", regs, model_pack());
  endtask

  initial begin
    bit a0, a1, a2;
    logic [7:0] d;
    logic [31:0] snap;
    void'($urandom(32'h5EED_0042));
    mdl[0] = 8'h7C; mdl[1] = 8'h00; mdl[2] = 8'hEA; mdl[3] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(regs == 32'h00EA_007C, "R1 reset regs", regs, 32'h00EA_007C);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", {31'd0, sda_oe}, 32'd0);

    // R2 foreign address ignored
    bus_start(); wr_byte(8'hA4, a0); wr_byte(8'h81, a1); wr_byte(8'h55, a2); bus_stop();
    chk(!a0 && !a1 && !a2, "R2 no ack foreign", {29'd0, a0, a1, a2}, 32'd0);
    chk(regs == model_pack(), "R2 regs unchanged", regs, model_pack());

    // R3 index out of range
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h85, a1); wr_byte(8'h33, a2); bus_stop();
    chk(a0 && !a1 && !a2, "R3 bad index nack", {29'd0, a0, a1, a2}, 32'd4);
    chk(regs == model_pack(), "R3 regs unchanged", regs, model_pack());

    // R4 block command with nonzero low bits
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h01, a1); wr_byte(8'h02, a2); bus_stop();
    chk(a0 && !a1 && !a2, "R4 bad block nack", {29'd0, a0, a1, a2}, 32'd4);

    // R5 directed
    byte_write(3, 8'hA5);
    byte_write(0, 8'h3C);

    // R6 read with continuation past end
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h82, a1); bus_rstart(); wr_byte(8'hD3, a2);
    chk(a0 && a1 && a2, "R6 acks", {29'd0, a0, a1, a2}, 32'd7);
    rd_byte(d, 1); chk(d == model_rd(2), "R6 first", {24'd0, d}, {24'd0, model_rd(2)});
    rd_byte(d, 1); chk(d == model_rd(3), "R6 next", {24'd0, d}, {24'd0, model_rd(3)});
    rd_byte(d, 0); chk(d == 8'h00, "R6 past end", {24'd0, d}, 32'd0);
    // R12 after NACK the line stays free
    for (int i = 7; i >= 0; i--) begin bit b; get_bit(b); d[i] = b; end
    chk(d == 8'hFF, "R12 released after nack", {24'd0, d}, 32'hFF);
    bus_stop();

    // R7 overflow: six data bytes, last two dropped
    block_write(6, 0);
    // R9 partial block: stop after two bytes
    block_write(2, 1);

    // R8 block read: count then registers then zero
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h00, a1); bus_rstart(); wr_byte(8'hD3, a2);
    rd_byte(d, 1); chk(d == 8'h04, "R8 count", {24'd0, d}, 32'd4);
    for (int k = 0; k < 5; k++) begin
      rd_byte(d, k != 4);
      chk(d == model_rd(k), "R8 data", {24'd0, d}, {24'd0, model_rd(k)});
    end
    bus_stop();

    // R10 stop in the middle of a data byte
    snap = regs;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h81, a1);
    send_bit(1); send_bit(1); send_bit(0); send_bit(1);
    bus_stop();
    chk(regs == snap, "R10 stop mid-byte no write", regs, snap);
    chk(sda_oe == 1'b0, "R10 released", {31'd0, sda_oe}, 32'd0);
    // R10 start in the middle of a data byte: following byte ignored
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h81, a1);
    send_bit(1); send_bit(0); send_bit(1);
    h_sda = 1; qw(); h_scl = 1; qw(); h_sda = 0; qw(); h_scl = 0; qw();
    wr_byte(8'hD2, a2); bus_stop();
    chk(!a2, "R10 start mid-byte ignored", {31'd0, a2}, 32'd0);
    chk(regs == snap, "R10 regs unchanged", regs, snap);

    // random mix
    for (int it = 0; it < 24; it++) begin
      int op, idx, m;
      op = int'($urandom_range(0, 3));
      idx = int'($urandom_range(0, 3));
      case (op)
        0: byte_write(idx, 8'($urandom));
        1: begin
          bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h80 | 8'(idx), a1); bus_rstart(); wr_byte(8'hD3, a2);
          rd_byte(d, 0); bus_stop();
          chk(d == mdl[idx], "R6 random read", {24'd0, d}, {24'd0, mdl[idx]});
        end
        2: block_write(int'($urandom_range(0, 6)), 0);
        default: begin
          m = int'($urandom_range(1, 6));
          bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h00, a1); bus_rstart(); wr_byte(8'hD3, a2);
          rd_byte(d, 1); chk(d == 8'h04, "R8 random count", {24'd0, d}, 32'd4);
          for (int k = 0; k < m; k++) begin
            rd_byte(d, k != m - 1);
            chk(d == model_rd(k), "R8 random data", {24'd0, d}, {24'd0, model_rd(k)});
          end
          bus_stop();
        end
      endcase
    end

    chk(r11_viol == 0, "R11 sda_oe moved with SCL high", r11_viol, 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule